// File: doc/BRIEF.md
# Accumulator ALU with Five-Flag Status Byte

This block is the arithmetic and logic datapath of a small accumulator machine. Each issued operation combines the accumulator with a second operand and writes the result back into the accumulator on the same clock edge. The operations are add, add with carry-in, subtract, subtract with borrow-in, increment, decrement, bitwise AND, OR and XOR, plus a move that loads the operand directly.

Alongside the result, the block builds a status byte with five condition bits: sign, zero, a nibble carry out of bit 3, even parity and the main carry. These bits live in flip-flops and change only when the caller asks for a flag update in the same cycle as the operation. The status byte has a fixed layout, so a downstream reader can test or save it as a single byte. Both the accumulator and the status byte are registered outputs.

Top module: `alu8_core`

## Requirements
- R1: When `op_valid` is high, op code 0 (add) stores acc + B and op code 1 (add with carry) stores acc + B + CY, truncated to 8 bits. In both cases CY is the carry out of bit 7.
- R2: Op code 2 (subtract) computes acc + ~B + 1 and op code 3 (subtract with borrow) computes acc + ~B + (1 - CY). Both store the low 8 bits. CY is set when there is no carry out of bit 7, which means a borrow occurred.
- R3: For op codes 0 to 5, AC is the carry out of bit 3 of the addition the block actually performs. Subtracts use the inverted operand and carry-in, increment adds 1, and decrement adds 0xFF.
- R4: After every flag-writing operation with op codes 0 to 8, S equals bit 7 of the new accumulator and Z is set exactly when the new accumulator is 0.
- R5: After every flag-writing operation with op codes 0 to 8, P is 1 when the new accumulator holds an even number of 1 bits and 0 when that number is odd.
- R6: Op code 4 (increment) stores acc + 1 and op code 5 (decrement) stores acc - 1, both modulo 256. Neither changes CY.
- R7: Op codes 6, 7 and 8 store acc AND B, acc OR B and acc XOR B. They clear CY, set AC for AND and clear AC for OR and XOR.
- R8: The status byte places S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bit 1 always reads 1, and bits 3 and 5 always read 0.
- R9: The status byte changes only on a clock edge where `op_valid` and `flag_we` are both high. The accumulator changes only when `op_valid` is high.
- R10: Op code 9 (move) loads B into the accumulator and never changes the status byte. Op codes 10 to 15 change neither the accumulator nor the status byte.
- R11: A synchronous active-high reset sets the accumulator to 0x00 and the status byte to 0x02. Reset overrides any operation issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue the operation in `op_code` on this edge |
| op_code | input | 4 | Operation select (0..9 defined, 10..15 inert) |
| operand_b | input | W | Second operand |
| flag_we | input | 1 | Update the status byte with this operation |
| acc_q | output | W | Registered accumulator |
| flags_q | output | 8 | Registered status byte |

## Verification
On every cycle, the assertions check several relations between the registered outputs. S, Z and P must agree with the accumulator after each flag write. The status byte must hold when no flag write occurs. Increment and decrement must keep CY, logical operations must produce their fixed CY and AC values, and a move must copy the operand. The carry, borrow and nibble-carry values of additions and subtractions depend on the operands. Only the bench's reference model can show these are right. It covers directed boundary operands, such as 0xFF+1, 0x00-1, borrow-in chains and nibble rollovers, followed by a long random stream that mixes flag writes with inert op codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_ADD = 4'd0;
  localparam logic [OPW-1:0] OP_ADC = 4'd1;
  localparam logic [OPW-1:0] OP_SUB = 4'd2;
  localparam logic [OPW-1:0] OP_SBB = 4'd3;
  localparam logic [OPW-1:0] OP_INC = 4'd4;
  localparam logic [OPW-1:0] OP_DEC = 4'd5;
  localparam logic [OPW-1:0] OP_AND = 4'd6;
  localparam logic [OPW-1:0] OP_OR  = 4'd7;
  localparam logic [OPW-1:0] OP_XOR = 4'd8;
  localparam logic [OPW-1:0] OP_MOV = 4'd9;

  // status byte bit positions
  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_AC = 4;
  localparam int FB_P  = 2;
  localparam int FB_CY = 0;
  localparam int FB_ONE = 1;

  localparam logic [7:0] FLAGS_RESET = 8'h02;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         c_aux
);
  localparam int AUX_BIT = (W / 2) - 1;

  logic [W:0] carry;
  assign carry[0] = cin;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = a[i] ^ b[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  endgenerate

  assign c_out = carry[W];
  assign c_aux = carry[AUX_BIT+1];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_sel_e   sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flaggen.sv
module alu8_flaggen
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] result,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [7:0]   flag_byte
);
  logic par_even;
  assign par_even = ~(^result);

  always_comb begin
    flag_byte         = '0;
    flag_byte[FB_S]   = result[W-1];
    flag_byte[FB_Z]   = (result == '0);
    flag_byte[FB_AC]  = ac_in;
    flag_byte[FB_P]   = par_even;
    flag_byte[FB_ONE] = 1'b1;
    flag_byte[FB_CY]  = cy_in;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] operand_b,
  input  logic         flag_we,
  output logic [W-1:0] acc_q,
  output logic [7:0]   flags_q
);
  logic [W-1:0] add_b;
  logic         add_cin;
  logic         is_sub;
  logic         keep_cy;
  logic         use_logic;
  logic         is_mov;
  logic         legal;
  logic_sel_e   lsel;

  logic [W-1:0] sum;
  logic         c_out;
  logic         c_aux;
  logic [W-1:0] logic_y;
  logic [W-1:0] result;
  logic         cy_next;
  logic         ac_next;
  logic [7:0]   flag_next;
  logic         cy_now;

  assign cy_now = flags_q[FB_CY];

  // operand steering into the shared adder
  always_comb begin
    add_b     = operand_b;
    add_cin   = 1'b0;
    is_sub    = 1'b0;
    keep_cy   = 1'b0;
    use_logic = 1'b0;
    is_mov    = 1'b0;
    legal     = 1'b1;
    lsel      = LG_AND;
    unique case (op_code)
      OP_ADD: begin add_b = operand_b;  add_cin = 1'b0; end
      OP_ADC: begin add_b = operand_b;  add_cin = cy_now; end
      OP_SUB: begin add_b = ~operand_b; add_cin = 1'b1;    is_sub = 1'b1; end
      OP_SBB: begin add_b = ~operand_b; add_cin = ~cy_now; is_sub = 1'b1; end
      OP_INC: begin add_b = '0;         add_cin = 1'b1;    keep_cy = 1'b1; end
      OP_DEC: begin add_b = '1;         add_cin = 1'b0;    keep_cy = 1'b1; end
      OP_AND: begin use_logic = 1'b1; lsel = LG_AND; end
      OP_OR:  begin use_logic = 1'b1; lsel = LG_OR;  end
      OP_XOR: begin use_logic = 1'b1; lsel = LG_XOR; end
      OP_MOV: begin is_mov = 1'b1; end
      default: legal = 1'b0;
    endcase
  end

  alu8_adder #(.W(W)) adder_i (
    .a     (acc_q),
    .b     (add_b),
    .cin   (add_cin),
    .sum   (sum),
    .c_out (c_out),
    .c_aux (c_aux)
  );

  alu8_logic #(.W(W)) logic_i (
    .a   (acc_q),
    .b   (operand_b),
    .sel (lsel),
    .y   (logic_y)
  );

  always_comb begin
    if (is_mov)         result = operand_b;
    else if (use_logic) result = logic_y;
    else                result = sum;
  end

  always_comb begin
    if (use_logic)    cy_next = 1'b0;
    else if (keep_cy) cy_next = cy_now;
    else if (is_sub)  cy_next = ~c_out;
    else              cy_next = c_out;
    if (use_logic)    ac_next = (lsel == LG_AND);
    else              ac_next = c_aux;
  end

  alu8_flaggen #(.W(W)) flaggen_i (
    .result    (result),
    .cy_in     (cy_next),
    .ac_in     (ac_next),
    .flag_byte (flag_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      flags_q <= FLAGS_RESET;
    end else if (op_valid && legal) begin
      acc_q <= result;
      if (flag_we && !is_mov) flags_q <= flag_next;
    end
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [3:0]   op_code,
  input logic [W-1:0] operand_b,
  input logic         flag_we,
  input logic [W-1:0] acc_q,
  input logic [7:0]   flags_q
);
  logic fw_arith;
  logic fw_incdec;
  logic fw_logic;
  assign fw_arith  = op_valid && flag_we && (op_code <= OP_XOR);
  assign fw_incdec = op_valid && flag_we && (op_code == OP_INC || op_code == OP_DEC);
  assign fw_logic  = op_valid && flag_we && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR);

  AST_RESET_VALUE: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && flags_q == FLAGS_RESET)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_q) && $stable(flags_q))); // R9

  AST_NO_FLAG_WRITE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !flag_we) |=> $stable(flags_q)); // R9

  AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
    fw_arith |=> (flags_q[FB_S] == acc_q[W-1] && flags_q[FB_Z] == (acc_q == '0))); // R4

  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
    fw_arith |=> (flags_q[FB_P] == ~(^acc_q))); // R5

  AST_INCDEC_KEEP_CY: assert property (@(posedge clk) disable iff (rst)
    fw_incdec |=> (flags_q[FB_CY] == $past(flags_q[FB_CY]))); // R6

  AST_INC_VALUE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_INC) |=> (acc_q == $past(acc_q) + 1'b1)); // R6

  AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    fw_logic |=> (!flags_q[FB_CY] && flags_q[FB_AC] == ($past(op_code) == OP_AND))); // R7

  AST_MOV_LOAD: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_MOV) |=> (acc_q == $past(operand_b) && $stable(flags_q))); // R10

  AST_INERT_CODE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > OP_MOV) |=> ($stable(acc_q) && $stable(flags_q))); // R10
endmodule

bind alu8_core alu8_core_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .operand_b (operand_b),
  .flag_we   (flag_we),
  .acc_q     (acc_q),
  .flags_q   (flags_q)
);

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] operand_b;
  logic       flag_we;
  logic [7:0] acc_q;
  logic [7:0] flags_q;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int m_acc;
  int m_flags;

  always #10 clk = ~clk;

  alu8_core #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand_b(operand_b), .flag_we(flag_we), .acc_q(acc_q), .flags_q(flags_q)
  );

  function automatic string req_of(int op, bit v, bit we);
    if (!v) return "R9";
    if (op == 9) return "R10";
    if (op > 9) return "R10";
    if (!we) return "R9";
    case (op)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic int ones(int x);
    int c = 0;
    for (int i = 0; i < 8; i++) if ((x >> i) & 1) c++;
    return c;
  endfunction

  // behavioural model of one clock edge
  task automatic model_step(bit v, int op, int b, bit we);
    int r, c, h, cy;
    bit wr_flags;
    cy = m_flags & 1;
    if (!v || op > 9) return;
    if (op == 9) begin m_acc = b; return; end
    c = cy; h = 0; r = 0;
    case (op)
      0: begin r = m_acc + b;              h = ((m_acc % 16) + (b % 16)) > 15;          c = r > 255; end
      1: begin r = m_acc + b + cy;         h = ((m_acc % 16) + (b % 16) + cy) > 15;     c = r > 255; end
      2: begin r = m_acc + (255 - b) + 1;  h = ((m_acc % 16) + (15 - b % 16) + 1) > 15; c = (r <= 255); end
      3: begin r = m_acc + (255 - b) + (1 - cy);
               h = ((m_acc % 16) + (15 - b % 16) + (1 - cy)) > 15; c = (r <= 255); end
      4: begin r = m_acc + 1;   h = (m_acc % 16) == 15; end
      5: begin r = m_acc + 255; h = (m_acc % 16) != 0;  end
      6: begin r = m_acc & b; h = 1; c = 0; end
      7: begin r = m_acc | b; h = 0; c = 0; end
      default: begin r = m_acc ^ b; h = 0; c = 0; end
    endcase
    r = r % 256;
    m_acc = r;
    wr_flags = we;
    if (wr_flags)
      m_flags = ((r >= 128) ? 128 : 0) + ((r == 0) ? 64 : 0) + (h ? 16 : 0)
              + ((ones(r) % 2 == 0) ? 4 : 0) + 2 + c;
  endtask

  task automatic compare(string req);
    n_checks++;
    if (acc_q !== 8'(m_acc) || flags_q !== 8'(m_flags)) begin
      n_fail++;
      $display("FAIL %s: acc=%02h flags=%02h expected acc=%02h flags=%02h",
               req, acc_q, flags_q, m_acc, m_flags);
    end
  endtask

  // drive at negedge, let one posedge pass, check at next negedge
  task automatic step(bit v, int op, int b, bit we, string req = "");
    op_valid  = v;
    op_code   = 4'(op);
    operand_b = 8'(b);
    flag_we   = we;
    @(posedge clk);
    model_step(v, op, b, we);
    @(negedge clk);
    compare(req == "" ? req_of(op, v, we) : req);
  endtask

  task automatic load(int val);
    step(1, 9, val, 1, "R10");
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b1; op_code = 4'd0; operand_b = 8'hFF; flag_we = 1'b1;
    m_acc = 0; m_flags = 2;
    repeat (3) @(negedge clk);
    compare("R11");
    rst = 1'b0;

    // R1 add: full carry-out with nibble carry, then add with carry-in
    load(8'h3A); step(1, 0, 8'hC6, 1, "R1");
    step(1, 1, 8'h00, 1, "R1");
    load(8'h7F); step(1, 0, 8'h01, 1, "R4");
    // R2 subtract with borrow and borrow-in chain
    load(8'h00); step(1, 2, 8'h01, 1, "R2");
    step(1, 3, 8'h00, 1, "R2");
    load(8'h10); step(1, 2, 8'h01, 1, "R3");
    load(8'h55); step(1, 2, 8'h55, 1, "R2");
    // R6 increment / decrement wrap, CY kept
    load(8'hFF); step(1, 4, 0, 1, "R6");
    step(1, 5, 0, 1, "R6");
    load(8'h0F); step(1, 4, 0, 1, "R3");
    // R7 logicals
    load(8'hF0); step(1, 6, 8'h3C, 1, "R7");
    step(1, 7, 8'h03, 1, "R7");
    step(1, 8, 8'hFF, 1, "R5");
    // R8 layout after flags all set/clear patterns
    load(8'h00); step(1, 2, 8'h00, 1, "R8");
    // R9 no flag write, idle
    load(8'h80); step(1, 0, 8'h80, 0, "R9");
    step(0, 0, 8'h11, 1, "R9");
    // R10 move keeps flags, inert codes
    step(1, 9, 8'h00, 1, "R10");
    step(1, 12, 8'h44, 1, "R10");
    step(1, 15, 8'h01, 0, "R10");

    for (int k = 0; k < 400; k++)
      step(($urandom_range(0, 9) != 0), $urandom_range(0, 15),
           $urandom_range(0, 255), ($urandom_range(0, 4) != 0));

    // reset mid-stream
    rst = 1'b1; op_valid = 1'b1; op_code = 4'd9; operand_b = 8'hAA;
    @(posedge clk); @(negedge clk);
    m_acc = 0; m_flags = 2;
    compare("R11");
    rst = 1'b0;

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule